// File: doc/BRIEF.md
# Address-Matched ECC Check-Bit Corruptor

This block sits on the write path of a memory channel, just after ECC generation. It deliberately damages the ECC check bits of chosen writes so that the correction and error-reporting logic further down the channel can be tested. Software loads three configuration registers: an address pattern, a mask of address fields to leave out of the comparison, and a mask of ECC bits to invert. It then writes a command register that arms the injector and picks its mode.

Each write beat carries a rank, bank, row and column address, a beat index within its cache line, and an ECC byte. The block passes every beat through one register stage. When the injector is armed and the beat qualifies, the ECC byte leaves the stage XORed with the flip mask. A beat qualifies when its address matches the pattern and, if the half restriction is on, it falls in the selected half of the line. Inverting one ECC bit gives a correctable error. Inverting two or more bits can give an uncorrectable one.

In one-shot mode the injector disarms itself after the first beat it corrupts. In repeat mode it stays armed until software writes the command register again. A sticky status output shows whether any beat has been corrupted since the last arm.

Top module: `ecc_inject_top`

## Requirements
- R1: After a synchronous active-low reset, out_valid, out_injected and inj_seen are 0 and the injector is disarmed.
- R2: A write beat presented with wr_valid=1 appears on out_valid/out_ecc exactly one cycle later. When the beat does not qualify, out_ecc equals wr_ecc and out_injected is 0.
- R3: An address comparison succeeds when every field not ignored is equal. The match register (reg_sel=0) holds the column in bits [9:0], the row in [25:10], the bank in [28:26] and the rank in [31:29]. In the ignore register (reg_sel=1), bit 0 = column, bit 1 = row, bit 2 = bank and bit 3 = rank. A 1 drops that field, so the field always matches.
- R4: For a qualifying beat, out_ecc = wr_ecc XOR the flip mask, and out_injected is 1. The flip mask is held in bits [7:0] of reg_sel=2.
- R5: The command register is reg_sel=3: bit 0 = arm, bit 1 = repeat, bit 2 = half restriction on, bit 3 = half select. A command write with arm=1 and repeat=0 arms the injector. It then corrupts only the first qualifying beat and disarms.
- R6: With repeat=1, every qualifying beat is corrupted until a command write with arm=0. After that write, matching beats pass unchanged.
- R7: With the half restriction on, only beats whose index lies in the selected half qualify. Half select 0 means beats 0 and 1 of a four-beat line; half select 1 means beats 2 and 3.
- R8: A write to reg_sel 0, 1 or 2 disarms the injector. Matching beats that follow pass unchanged until the next arming command.
- R9: inj_seen becomes 1 in the cycle a corrupted beat is output and stays 1. A command write with arm=1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Configuration register write strobe |
| reg_sel | input | 2 | Register select: 0 match, 1 ignore, 2 flip mask, 3 command |
| reg_wdata | input | 32 | Configuration write data |
| wr_valid | input | 1 | Write beat valid |
| wr_rank | input | 3 | Rank of the write |
| wr_bank | input | 3 | Bank of the write |
| wr_row | input | 16 | Row of the write |
| wr_col | input | 10 | Column of the write |
| wr_beat | input | 2 | Beat index within the cache line |
| wr_ecc | input | 8 | ECC check bits of the beat |
| out_valid | output | 1 | Delayed beat valid |
| out_ecc | output | 8 | ECC bits, possibly corrupted |
| out_injected | output | 1 | This output beat was corrupted |
| inj_seen | output | 1 | Sticky: an injection happened since the last arm |

## Verification
The hardest cases to reach are the ones that depend on arming history. One is a second matching beat after a one-shot has already fired. Another is a matching beat that follows a configuration write made while armed. Neither is visible from a single beat. The stimulus builds each of these sequences on purpose: arm, corrupt one beat, then send the same address again; or arm in repeat mode, rewrite one register, then send a beat that would otherwise match. The half restriction is covered by sweeping all four beat indices under both half selects. Field masking is covered by varying the ignored fields to extreme values while changing a compared field by one step.

// File: rtl/ecci_pkg.sv
// Shared types for the ECC check-bit corruptor.
// Assumes a two-bit register select and a four-bit command layout.
package ecci_pkg;

    typedef enum logic [1:0] {
        SEL_MATCH  = 2'd0,
        SEL_IGNORE = 2'd1,
        SEL_FLIP   = 2'd2,
        SEL_CMD    = 2'd3
    } reg_sel_e;

    localparam int NUM_FIELDS = 4;   // column, row, bank, rank

    // Command bit positions within the command register write data
    localparam int CMD_ARM_BIT   = 0;
    localparam int CMD_RPT_BIT   = 1;
    localparam int CMD_HEN_BIT   = 2;
    localparam int CMD_HSEL_BIT  = 3;

    typedef struct packed {
        logic rpt;       // keep armed after an injection
        logic half_en;   // restrict to one half of the line
        logic half_sel;  // 0: first half, 1: second half
    } inj_mode_t;

endpackage

// File: rtl/ecci_cfg_regs.sv
// Configuration registers and arming control.
// Holds the match pattern, the field-ignore mask, the ECC flip mask and the mode.
// Tracks the armed state and the sticky injection flag.
// Assumes ADDR_W <= REG_W and ECC_W <= REG_W.
// A register write in a cycle takes precedence over an injection in that cycle.
module ecci_cfg_regs
    import ecci_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 32,
    parameter int ECC_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [1:0]            reg_sel,
    input  logic [REG_W-1:0]      reg_wdata,
    input  logic                  fire,
    output logic [ADDR_W-1:0]     match_val,
    output logic [NUM_FIELDS-1:0] ign_mask,
    output logic [ECC_W-1:0]      flip_mask,
    output inj_mode_t             mode,
    output logic                  armed,
    output logic                  inj_seen
);

    logic wr_match, wr_ign, wr_flip, wr_cmd;

    // Decode which register the current write targets
    always_comb begin
        wr_match = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_MATCH);
        wr_ign   = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_IGNORE);
        wr_flip  = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_FLIP);
        wr_cmd   = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_CMD);
    end

    // Store the configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_val <= '0;
            ign_mask  <= '0;
            flip_mask <= '0;
            mode      <= '0;
        end else begin
            if (wr_match) match_val <= reg_wdata[ADDR_W-1:0];
            if (wr_ign)   ign_mask  <= reg_wdata[NUM_FIELDS-1:0];
            if (wr_flip)  flip_mask <= reg_wdata[ECC_W-1:0];
            if (wr_cmd) begin
                mode.rpt      <= reg_wdata[CMD_RPT_BIT];
                mode.half_en  <= reg_wdata[CMD_HEN_BIT];
                mode.half_sel <= reg_wdata[CMD_HSEL_BIT];
            end
        end
    end

    // Armed state: set by the command, cleared by a config write or a one-shot firing
    always_ff @(posedge clk) begin
        if (!rst_n)                                armed <= 1'b0;
        else if (wr_cmd)                           armed <= reg_wdata[CMD_ARM_BIT];
        else if (wr_match || wr_ign || wr_flip)    armed <= 1'b0;
        else if (fire && !mode.rpt)                armed <= 1'b0;
    end

    // Sticky injection flag, cleared on each arming
    always_ff @(posedge clk) begin
        if (!rst_n)                                inj_seen <= 1'b0;
        else if (wr_cmd && reg_wdata[CMD_ARM_BIT]) inj_seen <= 1'b0;
        else if (fire)                             inj_seen <= 1'b1;
    end

    p_oneshot_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !mode.rpt && !reg_wr_en) |=> !armed);

    p_repeat_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && mode.rpt && !reg_wr_en) |=> armed);

    p_cfg_write_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_sel_e'(reg_sel) != SEL_CMD) |=> !armed);

    p_arm_clears_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && reg_wdata[CMD_ARM_BIT]) |=> !inj_seen);

endmodule

// File: rtl/ecci_addr_match.sv
// Maskable multi-field address comparator.
// The address and the pattern are packed as {rank, bank, row, col}, column in the low bits.
// A set ignore bit forces its field to match. Purely combinational.
module ecci_addr_match
    import ecci_pkg::*;
#(
    parameter int RANK_W = 3,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16,
    parameter int COL_W  = 10,
    parameter int ADDR_W = RANK_W + BANK_W + ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [ADDR_W-1:0]     pattern,
    input  logic [NUM_FIELDS-1:0] ign,
    output logic                  hit
);

    localparam int F_LSB [NUM_FIELDS] = '{0, COL_W, COL_W + ROW_W, COL_W + ROW_W + BANK_W};
    localparam int F_WID [NUM_FIELDS] = '{COL_W, ROW_W, BANK_W, RANK_W};

    logic [NUM_FIELDS-1:0] fld_ok;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        // One field comparator, overridden by its ignore bit
        assign fld_ok[f] = ign[f] ||
            (addr[F_LSB[f] +: F_WID[f]] == pattern[F_LSB[f] +: F_WID[f]]);
    end

    assign hit = &fld_ok;

endmodule

// File: rtl/ecci_flip_stage.sv
// Output register stage that applies the flip mask to qualifying beats.
// Adds one cycle of latency. The companion data travels in a parallel pipeline elsewhere.
module ecci_flip_stage #(
    parameter int ECC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ECC_W-1:0] in_ecc,
    input  logic             corrupt,
    input  logic [ECC_W-1:0] flip_mask,
    output logic             out_valid,
    output logic [ECC_W-1:0] out_ecc,
    output logic             out_injected
);

    // Register the beat and XOR in the mask when it is to be corrupted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_ecc      <= '0;
            out_injected <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            out_ecc      <= corrupt ? (in_ecc ^ flip_mask) : in_ecc;
            out_injected <= in_valid && corrupt;
        end
    end

    p_inj_only_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_injected |-> out_valid);

    p_flip_applied_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && corrupt) |=> (out_ecc == ($past(in_ecc) ^ $past(flip_mask))));

    p_clean_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !corrupt) |=> (out_valid && !out_injected && out_ecc == $past(in_ecc)));

endmodule

// File: rtl/ecc_inject_top.sv
// Address-matched ECC check-bit corruptor, top level.
// Compares each write beat's address against a maskable pattern.
// When armed and the beat qualifies, inverts the selected ECC bits one cycle later.
// Assumes BEATS is even; the upper half of the beat indices forms the second half of the line.
module ecc_inject_top
    import ecci_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int RANK_W = 3,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16,
    parameter int COL_W  = 10,
    parameter int ECC_W  = 8,
    parameter int BEATS  = 4,
    parameter int BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              wr_valid,
    input  logic [RANK_W-1:0] wr_rank,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [BEAT_W-1:0] wr_beat,
    input  logic [ECC_W-1:0]  wr_ecc,
    output logic              out_valid,
    output logic [ECC_W-1:0]  out_ecc,
    output logic              out_injected,
    output logic              inj_seen
);

    localparam int ADDR_W = RANK_W + BANK_W + ROW_W + COL_W;

    logic [ADDR_W-1:0]     match_val;
    logic [NUM_FIELDS-1:0] ign_mask;
    logic [ECC_W-1:0]      flip_mask;
    inj_mode_t             mode;
    logic                  armed;
    logic                  addr_hit;
    logic                  half_ok;
    logic                  corrupt;
    logic                  fire;
    logic [ADDR_W-1:0]     beat_addr;

    assign beat_addr = {wr_rank, wr_bank, wr_row, wr_col};

    ecci_cfg_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .ECC_W(ECC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .fire      (fire),
        .match_val (match_val),
        .ign_mask  (ign_mask),
        .flip_mask (flip_mask),
        .mode      (mode),
        .armed     (armed),
        .inj_seen  (inj_seen)
    );

    ecci_addr_match #(
        .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
    ) u_match (
        .addr    (beat_addr),
        .pattern (match_val),
        .ign     (ign_mask),
        .hit     (addr_hit)
    );

    // Half-line qualifier: the beat index MSB selects the half
    always_comb begin
        half_ok = !mode.half_en || (wr_beat[BEAT_W-1] == mode.half_sel);
        corrupt = armed && addr_hit && half_ok;
        fire    = wr_valid && corrupt;
    end

    ecci_flip_stage #(.ECC_W(ECC_W)) u_flip (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (wr_valid),
        .in_ecc       (wr_ecc),
        .corrupt      (corrupt),
        .flip_mask    (flip_mask),
        .out_valid    (out_valid),
        .out_ecc      (out_ecc),
        .out_injected (out_injected)
    );

    p_ignore_all_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ign_mask == '1) |-> addr_hit);

    p_seen_follows_inj_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_injected |-> inj_seen);

endmodule

// File: tb/ecc_inject_top_tb_top.sv
// Scoreboard bench: the driver pushes expected beats, the monitor pops and compares them.
module ecc_inject_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        wr_valid = 1'b0;
    logic [2:0]  wr_rank = '0;
    logic [2:0]  wr_bank = '0;
    logic [15:0] wr_row = '0;
    logic [9:0]  wr_col = '0;
    logic [1:0]  wr_beat = '0;
    logic [7:0]  wr_ecc = '0;
    logic        out_valid;
    logic [7:0]  out_ecc;
    logic        out_injected;
    logic        inj_seen;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] ecc;
        logic       inj;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    ecc_inject_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .wr_valid(wr_valid), .wr_rank(wr_rank),
        .wr_bank(wr_bank), .wr_row(wr_row), .wr_col(wr_col), .wr_beat(wr_beat),
        .wr_ecc(wr_ecc), .out_valid(out_valid), .out_ecc(out_ecc),
        .out_injected(out_injected), .inj_seen(inj_seen)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare every output beat against the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "unexpected beat", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(out_ecc == e.ecc, e.tag, "ecc", out_ecc, e.ecc);
                check(out_injected == e.inj, e.tag, "injected", out_injected, e.inj);
            end
        end
    end

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic send_beat(input logic [2:0] rk, input logic [2:0] bk,
                             input logic [15:0] rw, input logic [9:0] cl,
                             input logic [1:0] bt, input logic [7:0] ecc,
                             input logic [7:0] exp_ecc, input logic exp_inj,
                             input string tag);
        exp_t e;
        @(negedge clk);
        wr_valid = 1'b1; wr_rank = rk; wr_bank = bk; wr_row = rw;
        wr_col = cl; wr_beat = bt; wr_ecc = ecc;
        e.ecc = exp_ecc; e.inj = exp_inj; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    localparam logic [31:0] PAT = {3'd2, 3'd5, 16'h1234, 10'h03C};

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        check(out_injected == 1'b0, "R1", "out_injected", out_injected, 0);
        check(inj_seen == 1'b0, "R1", "inj_seen", inj_seen, 0);
        rst_n = 1'b1;
        // R2: unarmed beats pass unchanged
        send_beat(2, 5, 16'h1234, 10'h03C, 0, 8'h5A, 8'h5A, 0, "R2");
        // R3/R4/R5: one-shot exact match, single-bit flip
        reg_write(2'd0, PAT);
        reg_write(2'd1, 32'h0);
        reg_write(2'd2, 32'h01);
        reg_write(2'd3, 32'h1);
        send_beat(2, 5, 16'h1234, 10'h03D, 0, 8'h33, 8'h33, 0, "R3");
        send_beat(2, 5, 16'h1234, 10'h03C, 0, 8'hA5, 8'hA4, 1, "R4");
        check(inj_seen == 1'b1, "R9", "inj_seen after injection", inj_seen, 1);
        send_beat(2, 5, 16'h1234, 10'h03C, 1, 8'h10, 8'h10, 0, "R5");
        // R6: repeat mode, row and column ignored, two-bit flip
        reg_write(2'd1, 32'h3);
        reg_write(2'd2, 32'h81);
        reg_write(2'd3, 32'h3);
        check(inj_seen == 1'b0, "R9", "inj_seen cleared by arm", inj_seen, 0);
        send_beat(2, 5, 16'h0001, 10'h001, 1, 8'h00, 8'h81, 1, "R6");
        send_beat(2, 5, 16'hFFFF, 10'h3FF, 2, 8'h81, 8'h00, 1, "R6");
        send_beat(2, 4, 16'h1234, 10'h03C, 0, 8'h42, 8'h42, 0, "R3");
        send_beat(3, 5, 16'h1234, 10'h03C, 0, 8'h42, 8'h42, 0, "R3");
        reg_write(2'd3, 32'h0);
        send_beat(2, 5, 16'h1234, 10'h03C, 0, 8'h77, 8'h77, 0, "R6");
        check(inj_seen == 1'b1, "R9", "inj_seen sticky", inj_seen, 1);
        // R7: half restriction, second half then first half
        reg_write(2'd3, 32'hF);
        for (int b = 0; b < 4; b++)
            send_beat(2, 5, 16'h1234, 10'h03C, 2'(b), 8'h11,
                      (b >= 2) ? 8'h90 : 8'h11, (b >= 2), "R7");
        reg_write(2'd3, 32'h7);
        for (int b = 0; b < 4; b++)
            send_beat(2, 5, 16'h1234, 10'h03C, 2'(b), 8'h11,
                      (b < 2) ? 8'h90 : 8'h11, (b < 2), "R7");
        // R8: config writes while armed disarm the injector
        reg_write(2'd3, 32'h3);
        reg_write(2'd2, 32'h0F);
        send_beat(2, 5, 16'h1234, 10'h03C, 0, 8'h55, 8'h55, 0, "R8");
        reg_write(2'd3, 32'h3);
        reg_write(2'd1, 32'h3);
        send_beat(2, 5, 16'h1234, 10'h03C, 0, 8'h55, 8'h55, 0, "R8");
        reg_write(2'd3, 32'h3);
        reg_write(2'd0, PAT);
        send_beat(2, 5, 16'h1234, 10'h03C, 0, 8'h55, 8'h55, 0, "R8");
        // R3: every field ignored matches any address; R5 one-shot afterwards
        reg_write(2'd1, 32'hF);
        reg_write(2'd3, 32'h1);
        send_beat(7, 0, 16'h0000, 10'h000, 3, 8'hF0, 8'hFF, 1, "R3");
        send_beat(1, 1, 16'h0F0F, 10'h155, 0, 8'hF0, 8'hF0, 0, "R5");
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R2", "beats left in scoreboard", sb_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule